// File: doc/BRIEF.md
# Selectable Sum/CRC Packet Check Unit

This unit builds the error-check value of a serial packet one byte per clock. A framer feeds it the packet content after DLE unstuffing, one byte per strobe, so a doubled 0x10 reaches the unit only once. In CRC mode the framer also passes the ETX byte; in sum mode it does not. The unit only accumulates, and the framer decides which bytes count. A start pulse clears the running state and latches the mode for the whole packet. Sum mode yields an 8-bit two's-complement block check. CRC mode yields a 16-bit reflected CRC with polynomial constant 0xA001, cleared to zero.

After the last content byte, the unit can be used in two ways. An emit pulse makes it put the check bytes out for transmission, least significant byte first. Check bytes taken from a received packet can also be presented to it one at a time. It then reports a one-cycle match or mismatch pulse the cycle after the final one arrives.

Top module: `pkt_check_unit`

## Requirements
- R1: After reset, chk_value is 0, tx_valid, tx_last, cmp_match and cmp_mismatch are 0, and sum mode is selected.
- R2: In sum mode (use_crc=0 latched), chk_value[7:0] is the two's complement of the modulo-256 sum of the accepted bytes and chk_value[15:8] is 0. The bytes 08 00 01 00 00 80 02 10 give 0x65.
- R3: In CRC mode (use_crc=1 latched), each accepted byte is XORed into the low 8 bits of a 16-bit register that starts at 0. The register is then shifted right eight times with 0 entering at bit 15, and XORed with 0xA001 after each shift whose dropped bit was 1. chk_value is that register, so the single byte 0x01 gives 0xC0C1.
- R4: A start pulse clears the accumulated state, latches use_crc as the packet mode, and resets the compare byte position. A byte with in_valid in the same cycle as start is discarded. use_crc has no effect outside a start cycle.
- R5: While in_valid is low, in_byte has no effect on chk_value.
- R6: In sum mode, an emit pulse in cycle t gives tx_valid=1, tx_last=1 and tx_byte=chk_value[7:0] (as it was in cycle t) in cycle t+1 only.
- R7: In CRC mode, an emit pulse in cycle t gives tx_byte=chk_value[7:0] in cycle t+1 with tx_last=0, then chk_value[15:8] in cycle t+2 with tx_last=1, with tx_valid high in both.
- R8: An emit pulse is ignored while a second CRC byte is still waiting to be sent. An emit while the final byte is on the outputs is accepted.
- R9: Received check bytes are compared in order against chk_value[7:0] and then chk_value[15:8] (CRC mode only). The cycle after the final one arrives, exactly one of cmp_match (all equal) or cmp_mismatch pulses for one cycle.
- R10: A received check sequence is 1 byte long in sum mode and 2 bytes long in CRC mode. The compare position returns to the first byte after the final one.
- R11: chk_value reflects an accepted byte in the cycle after its in_valid strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a packet: clear state, latch mode |
| use_crc | input | 1 | Mode select sampled at start: 0 sum, 1 CRC |
| in_valid | input | 1 | in_byte carries a content byte |
| in_byte | input | 8 | Unstuffed content byte |
| chk_value | output | 16 | Current check value (sum mode in low byte) |
| emit | input | 1 | Request transmission of the check bytes |
| tx_valid | output | 1 | tx_byte carries a check byte |
| tx_byte | output | 8 | Outgoing check byte, low byte first |
| tx_last | output | 1 | Final check byte of the sequence |
| cmp_valid | input | 1 | cmp_byte carries a received check byte |
| cmp_byte | input | 8 | Received check byte |
| cmp_match | output | 1 | Received check bytes all matched |
| cmp_mismatch | output | 1 | At least one received check byte differed |

## Verification
The bench builds the unit with its default constant 0xA001. Both the 0x65 sum vector and the 0xC0C1 single-byte CRC vector then apply literally, and the bit-serial reference model uses the same constant. Random packets lengths of 1 to 20 bytes cover many 0x10 and 0x03 values, and both emit sequences run back to back. Overlapping emit pulses and corrupted first or second received bytes reach every path in the compare position counter.

// File: rtl/pktchk_pkg.sv
package pktchk_pkg;

    localparam int BYTE_W = 8;
    localparam int CRC_W  = 2 * BYTE_W;
    localparam logic [CRC_W-1:0] CRC_POLY_DEF = 16'hA001;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        CHK_SUM = 1'b0,
        CHK_CRC = 1'b1
    } chk_mode_e;

    typedef struct packed {
        byte_t hi;
        byte_t lo;
    } chk_pair_t;

    function automatic byte_t sum_to_bcc(input byte_t s);
        return byte_t'(~s + 1'b1);
    endfunction

    // Whole-byte CRC update: eight shift steps unrolled into one cycle.
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input byte_t b,
                                                  input logic [CRC_W-1:0] poly);
        logic [CRC_W-1:0] r;
        r = c ^ {{(CRC_W-BYTE_W){1'b0}}, b};
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[0] ? ((r >> 1) ^ poly) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/chk_accum.sv
module chk_accum
    import pktchk_pkg::*;
#(
    parameter logic [CRC_W-1:0] POLY = CRC_POLY_DEF
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      use_crc,
    input  logic      in_valid,
    input  byte_t     in_byte,
    output chk_mode_e mode,
    output chk_pair_t value
);

    byte_t            sum_q;
    logic [CRC_W-1:0] crc_q;
    chk_mode_e        mode_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q  <= '0;
            crc_q  <= '0;
            mode_q <= CHK_SUM;
        end else if (start) begin
            sum_q  <= '0;
            crc_q  <= '0;
            mode_q <= use_crc ? CHK_CRC : CHK_SUM;
        end else if (in_valid) begin
            sum_q  <= byte_t'(sum_q + in_byte);
            crc_q  <= crc_step(crc_q, in_byte, POLY);
        end
    end

    assign mode  = mode_q;
    assign value = (mode_q == CHK_CRC) ? chk_pair_t'(crc_q)
                                       : chk_pair_t'({{BYTE_W{1'b0}}, sum_to_bcc(sum_q)});

    assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
        start |=> (value == '0));

    assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!start && !in_valid) |=> $stable(value));

    assert_sum_hi_R2: assert property (@(posedge clk) disable iff (rst)
        (mode == CHK_SUM) |-> (value.hi == '0));

endmodule

// File: rtl/chk_emit.sv
module chk_emit
    import pktchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      emit,
    input  chk_mode_e mode,
    input  chk_pair_t value,
    output logic      tx_valid,
    output byte_t     tx_byte,
    output logic      tx_last
);

    logic  valid_q, last_q, pend_q;
    byte_t byte_q, pend_byte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q     <= 1'b0;
            last_q      <= 1'b0;
            pend_q      <= 1'b0;
            byte_q      <= '0;
            pend_byte_q <= '0;
        end else if (pend_q) begin
            valid_q <= 1'b1;
            last_q  <= 1'b1;
            byte_q  <= pend_byte_q;
            pend_q  <= 1'b0;
        end else if (emit) begin
            valid_q     <= 1'b1;
            byte_q      <= value.lo;
            last_q      <= (mode == CHK_SUM);
            pend_q      <= (mode == CHK_CRC);
            pend_byte_q <= value.hi;
        end else begin
            valid_q <= 1'b0;
            last_q  <= 1'b0;
        end
    end

    assign tx_valid = valid_q;
    assign tx_byte  = byte_q;
    assign tx_last  = last_q;

    assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
        tx_last |-> tx_valid);

    assert_pair_R7: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_last) |=> (tx_valid && tx_last));

endmodule

// File: rtl/chk_compare.sv
module chk_compare
    import pktchk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      cmp_valid,
    input  byte_t     cmp_byte,
    input  chk_mode_e mode,
    input  chk_pair_t value,
    output logic      cmp_match,
    output logic      cmp_mismatch
);

    logic  idx_q, bad_q, match_q, mis_q;
    byte_t expect_b;
    logic  bad_n, final_b;

    always_comb begin
        expect_b = idx_q ? value.hi : value.lo;
        bad_n    = bad_q | (cmp_byte != expect_b);
        final_b  = (mode == CHK_SUM) || idx_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= 1'b0;
            bad_q   <= 1'b0;
            match_q <= 1'b0;
            mis_q   <= 1'b0;
        end else begin
            match_q <= 1'b0;
            mis_q   <= 1'b0;
            if (start) begin
                idx_q <= 1'b0;
                bad_q <= 1'b0;
            end else if (cmp_valid) begin
                if (final_b) begin
                    match_q <= !bad_n;
                    mis_q   <= bad_n;
                    idx_q   <= 1'b0;
                    bad_q   <= 1'b0;
                end else begin
                    idx_q <= 1'b1;
                    bad_q <= bad_n;
                end
            end
        end
    end

    assign cmp_match    = match_q;
    assign cmp_mismatch = mis_q;

    assert_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(cmp_match && cmp_mismatch));

    assert_cause_R9: assert property (@(posedge clk) disable iff (rst)
        (cmp_match || cmp_mismatch) |-> $past(cmp_valid));

    assert_sum_len_R10: assert property (@(posedge clk) disable iff (rst)
        (cmp_valid && !start && mode == CHK_SUM) |=> (cmp_match || cmp_mismatch));

endmodule

// File: rtl/pkt_check_unit.sv
module pkt_check_unit
    import pktchk_pkg::*;
#(
    parameter logic [15:0] CRC_POLY = CRC_POLY_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        use_crc,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic [15:0] chk_value,
    input  logic        emit,
    output logic        tx_valid,
    output logic [7:0]  tx_byte,
    output logic        tx_last,
    input  logic        cmp_valid,
    input  logic [7:0]  cmp_byte,
    output logic        cmp_match,
    output logic        cmp_mismatch
);

    chk_mode_e mode;
    chk_pair_t value;

    chk_accum #(.POLY(CRC_POLY)) u_accum (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .use_crc  (use_crc),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .mode     (mode),
        .value    (value)
    );

    chk_emit u_emit (
        .clk      (clk),
        .rst      (rst),
        .emit     (emit),
        .mode     (mode),
        .value    (value),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_last  (tx_last)
    );

    chk_compare u_cmp (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .cmp_valid    (cmp_valid),
        .cmp_byte     (cmp_byte),
        .mode         (mode),
        .value        (value),
        .cmp_match    (cmp_match),
        .cmp_mismatch (cmp_mismatch)
    );

    assign chk_value = value;

endmodule

// File: tb/sim_pkt_check_unit.sv
`timescale 1ns/1ps
module sim_pkt_check_unit;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, use_crc = 0, in_valid = 0, emit = 0, cmp_valid = 0;
    logic [7:0] in_byte = 0, cmp_byte = 0;
    logic [15:0] chk_value;
    logic tx_valid, tx_last, cmp_match, cmp_mismatch;
    logic [7:0] tx_byte;

    int vectors = 0;
    int fails   = 0;
    int cycles  = 0;

    always #2.5 clk = ~clk;

    pkt_check_unit u0 (
        .clk(clk), .rst(rst), .start(start), .use_crc(use_crc),
        .in_valid(in_valid), .in_byte(in_byte), .chk_value(chk_value),
        .emit(emit), .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_last(tx_last),
        .cmp_valid(cmp_valid), .cmp_byte(cmp_byte),
        .cmp_match(cmp_match), .cmp_mismatch(cmp_mismatch)
    );

    // ---------------- behavioural reference model ----------------
    int         m_sum;
    logic [15:0] m_crc;
    bit         m_mode;
    logic [7:0] txq[$];
    bit         e_tx_valid, e_tx_last;
    logic [7:0] e_tx_byte;
    int         m_pos;
    bit         m_bad;
    bit         e_match, e_mis;
    logic [15:0] cur;
    logic [7:0] want;

    function automatic logic [15:0] ref_value();
        if (m_mode) return m_crc;
        return {8'h00, 8'((256 - (m_sum % 256)) % 256)};
    endfunction

    function automatic logic [15:0] serial_crc(logic [15:0] c, logic [7:0] b);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            bit fb = r[0] ^ b[i];
            r = r >> 1;
            if (fb) r = r ^ 16'hA001;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        cur = ref_value();
        if (rst) begin
            m_sum = 0; m_crc = 0; m_mode = 0; txq.delete();
            e_tx_valid = 0; e_tx_last = 0; e_tx_byte = 0;
            m_pos = 0; m_bad = 0; e_match = 0; e_mis = 0;
        end else begin
            // transmit side
            if (txq.size() > 0) begin
                e_tx_byte = txq.pop_front();
                e_tx_valid = 1; e_tx_last = 1;
            end else if (emit) begin
                e_tx_byte = cur[7:0]; e_tx_valid = 1; e_tx_last = !m_mode;
                if (m_mode) txq.push_back(cur[15:8]);
            end else begin
                e_tx_valid = 0; e_tx_last = 0;
            end
            // receive compare side
            e_match = 0; e_mis = 0;
            if (start) begin
                m_pos = 0; m_bad = 0;
            end else if (cmp_valid) begin
                want = (m_pos == 0) ? cur[7:0] : cur[15:8];
                if (cmp_byte != want) m_bad = 1;
                if (!m_mode || m_pos == 1) begin
                    e_match = !m_bad; e_mis = m_bad; m_pos = 0; m_bad = 0;
                end else m_pos = 1;
            end
            // accumulation
            if (start) begin
                m_sum = 0; m_crc = 0; m_mode = use_crc;
            end else if (in_valid) begin
                m_sum = m_sum + in_byte;
                m_crc = serial_crc(m_crc, in_byte);
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        logic [15:0] rv = ref_value();
        check(chk_value == rv, "R2/R3/R11 chk_value", chk_value, rv);
        check(tx_valid == e_tx_valid && tx_last == e_tx_last &&
              (!e_tx_valid || tx_byte == e_tx_byte), "R6/R7/R8 tx",
              {tx_valid, tx_last, tx_byte}, {e_tx_valid, e_tx_last, e_tx_byte});
        check(cmp_match == e_match && cmp_mismatch == e_mis, "R9/R10 cmp flags",
              {cmp_match, cmp_mismatch}, {e_match, e_mis});
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        compare_all();
        start = 0; in_valid = 0; emit = 0; cmp_valid = 0;
    endtask

    task automatic begin_pkt(input bit crc);
        start = 1; use_crc = crc; step();
        use_crc = $urandom_range(0, 1);
    endtask

    task automatic feed(input logic [7:0] b);
        in_valid = 1; in_byte = b; step();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog (all R) actual=%0d expected<150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] refv[8] = '{8'h08, 8'h00, 8'h01, 8'h00, 8'h00, 8'h80, 8'h02, 8'h10};
        logic [15:0] snap;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        // R1: reset state
        check(chk_value == 0 && !tx_valid && !tx_last && !cmp_match && !cmp_mismatch,
              "R1 reset outputs", {chk_value, tx_valid, cmp_match}, 0);
        step();

        // R2: reference sum vector, then R6 emit and R9 match
        begin_pkt(0);
        foreach (refv[i]) feed(refv[i]);
        check(chk_value == 16'h0065, "R2 sum vector", chk_value, 16'h0065);
        emit = 1; step();
        check(tx_valid && tx_last && tx_byte == 8'h65, "R6 single check byte",
              {tx_valid, tx_last, tx_byte}, {2'b11, 8'h65});
        step();
        check(!tx_valid, "R6 one cycle only", tx_valid, 0);
        cmp_valid = 1; cmp_byte = 8'h65; step();
        check(cmp_match && !cmp_mismatch, "R9 sum match", {cmp_match, cmp_mismatch}, 2'b10);
        step();
        check(!cmp_match, "R9 one-cycle pulse", cmp_match, 0);

        // R3: single byte CRC vector; R11 latency
        begin_pkt(1);
        feed(8'h01);
        check(chk_value == 16'hC0C1, "R3 CRC vector / R11 latency", chk_value, 16'hC0C1);
        // R7 + R8: emit, overlapping emit ignored
        emit = 1; step();
        check(tx_valid && !tx_last && tx_byte == 8'hC1, "R7 CRC low byte first",
              {tx_valid, tx_last, tx_byte}, {2'b10, 8'hC1});
        emit = 1; step();
        check(tx_valid && tx_last && tx_byte == 8'hC0, "R7 CRC high byte second / R8",
              {tx_valid, tx_last, tx_byte}, {2'b11, 8'hC0});
        step();
        check(!tx_valid, "R8 overlapping emit ignored", tx_valid, 0);
        // R8: emit while last byte on outputs accepted back to back
        emit = 1; step(); step();
        emit = 1; step();
        check(tx_valid && !tx_last && tx_byte == 8'hC1, "R8 back-to-back emit accepted",
              {tx_valid, tx_last, tx_byte}, {2'b10, 8'hC1});
        step(); step();

        // R10: CRC compare, bad first byte, good second -> mismatch
        cmp_valid = 1; cmp_byte = 8'h00; step();
        check(!cmp_match && !cmp_mismatch, "R10 no verdict after first CRC byte",
              {cmp_match, cmp_mismatch}, 0);
        cmp_valid = 1; cmp_byte = 8'hC0; step();
        check(cmp_mismatch && !cmp_match, "R9 CRC mismatch", {cmp_match, cmp_mismatch}, 2'b01);
        // position back to first byte: full correct pair matches
        cmp_valid = 1; cmp_byte = 8'hC1; step();
        cmp_valid = 1; cmp_byte = 8'hC0; step();
        check(cmp_match, "R10 position wrapped, CRC match", cmp_match, 1);

        // R4: start with in_valid in the same cycle discards the byte
        start = 1; use_crc = 0; in_valid = 1; in_byte = 8'h55; step();
        check(chk_value == 0, "R4 byte in start cycle discarded", chk_value, 0);
        // R4: use_crc change without start has no effect
        use_crc = 1; feed(8'h03);
        check(chk_value == 16'h00FD, "R4 mode latched at start", chk_value, 16'h00FD);
        // R5: junk with in_valid low
        snap = chk_value;
        in_byte = 8'hAA; step(); in_byte = 8'h10; step();
        check(chk_value == snap, "R5 in_valid low ignored", chk_value, snap);

        // random packets, both modes, compared every clock with the model
        for (int p = 0; p < 60; p++) begin
            bit crc = p[0];
            int len = $urandom_range(1, 20);
            logic [15:0] v;
            begin_pkt(crc);
            for (int k = 0; k < len; k++) begin
                int sel = $urandom_range(0, 3);
                logic [7:0] b = (sel == 0) ? 8'h10 : 8'($urandom);
                if ($urandom_range(0, 3) == 0) step();
                feed(b);
            end
            if (crc) feed(8'h03);
            v = ref_value();
            emit = 1; step(); step(); step();
            cmp_valid = 1;
            cmp_byte = ($urandom_range(0, 2) == 0) ? v[7:0] ^ 8'h01 : v[7:0];
            step();
            if (crc) begin
                cmp_valid = 1;
                cmp_byte = ($urandom_range(0, 2) == 0) ? v[15:8] ^ 8'h80 : v[15:8];
                step();
            end
            idle(2);
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule